// File: doc/BRIEF.md
# NAND Flash Block-Lock Protection Unit

This unit is the write and erase guard of a NAND flash controller. A small register interface holds a freely changeable soft-lock bit, a one-way lock-tight bit, a start-block and an end-block register, two interrupt enables and an edge-select bit for the ready/busy line. The controller presents each command's type and target block address. The unit rejects program and erase commands that fall outside the unlocked window while any lock is on. It gives the answer in the same cycle and records the attempt in a sticky illegal-access flag.

The ready/busy input passes through a two-stage synchronizer. A transition in the chosen direction is latched into a second sticky flag. Both flags are cleared by writing 1 to them. A level interrupt output is the OR of each flag gated by its enable. Lock-tight can only be cleared by reset or by a wake-from-sleep pulse. While lock-tight is set, the window registers are frozen so the protected area cannot be widened.

Register map (2-bit `regAddr`): 0 = CONTROL, 1 = STATUS, 2 = START block, 3 = END block. Command codes on `cmdType`: 0 = read, 1 = program, 2 = erase, 3 = reserved (treated as a read).

Top module: `nand_block_guard`

## Requirements
- R1: After reset, CONTROL reads 0x0001 (soft lock on, everything else off), START and END read 0, and `irq` is 0. With `rnbIn` held high through reset, STATUS reads 0x0004.
- R2: When CONTROL bit 0 (soft lock) and bit 1 (lock-tight) are both 0, no command is rejected and `cmdAccept` equals `cmdValid`.
- R3: When a lock is on, a program (1) or erase (2) command to block b is accepted only if START <= b < END. Otherwise `cmdReject` is 1 and `cmdAccept` is 0 in the same cycle as `cmdValid`.
- R4: When a lock is on and START equals END, or START exceeds END, every program and erase command is rejected.
- R5: Read (0) and reserved (3) commands are never rejected, whatever the lock state or address.
- R6: A rejected command sets STATUS bit 1 at the next clock edge. The bit stays set until a STATUS write with bit 1 = 1. A write of 0 to that bit leaves it unchanged.
- R7: Writing 1 to CONTROL bit 1 sets lock-tight. Writing 0 does not clear it. Only reset or a one-cycle `wakeClr` pulse clears it.
- R8: Software can set and clear CONTROL bit 0 at any time.
- R9: While lock-tight is set, writes to START and END are ignored.
- R10: `rnbIn` is synchronized through two flip-flops and its level is readable in STATUS bit 2. A transition in the direction chosen by CONTROL bit 4 (0 = rising, 1 = falling) sets STATUS bit 0. A transition in the other direction does not. STATUS bit 0 is cleared by writing 1 to it.
- R11: `irq` = (STATUS bit 1 AND CONTROL bit 2) OR (STATUS bit 0 AND CONTROL bit 3). Both enables reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wakeClr | input | 1 | Wake-from-sleep pulse that clears lock-tight |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for reads and writes |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational on regAddr) |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdType | input | 2 | Command code: 0 read, 1 program, 2 erase, 3 reserved |
| cmdBlock | input | 16 | Target block address |
| cmdAccept | output | 1 | Command may proceed |
| cmdReject | output | 1 | One-cycle strobe: command blocked |
| rnbIn | input | 1 | Asynchronous ready/busy line |
| irq | output | 1 | Level interrupt |

## Verification
The lock decision is tried against a table of vectors. The table covers blocks at the first and last unlocked block and one step outside each end, an empty window with equal bounds, an inverted window, a window reaching the top address, reads and reserved codes inside locked space, and the same addresses with the lock off. Together these separate an inclusive from an exclusive bound at each end and check that only program and erase are filtered. Directed sequences then check that lock-tight survives a clearing write but yields to the wake pulse, and that the window registers stay frozen while lock-tight holds. They also drive the ready/busy line in both directions under each edge selection, so a detector of the wrong polarity is caught.

// File: rtl/nbg_pkg.sv
package nbg_pkg;
  localparam int REG_W = 16;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_START = 2'd2;
  localparam logic [1:0] ADDR_END   = 2'd3;

  localparam int CTRL_SOFT = 0;
  localparam int CTRL_TIGHT = 1;
  localparam int CTRL_ILL_EN = 2;
  localparam int CTRL_RNB_EN = 3;
  localparam int CTRL_EDGE_FALL = 4;

  localparam int STAT_RNB_EV = 0;
  localparam int STAT_ILLEGAL = 1;
  localparam int STAT_RNB_LVL = 2;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_PROG  = 2'd1,
    CMD_ERASE = 2'd2,
    CMD_RSVD  = 2'd3
  } cmdKind_e;

  typedef struct packed {
    logic wrStart;
    logic wrEnd;
    logic freezeWindow;
    logic edgeFalling;
  } ctrlStrobe_t;
endpackage

// File: rtl/nbg_datapath.sv
module nbg_datapath
  import nbg_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobes,
  input  logic [REG_W-1:0] wrData,
  input  logic [BLK_W-1:0] cmdBlock,
  input  logic             rnbIn,
  output logic             inWindow,
  output logic             rnbLevel,
  output logic             rnbEdge,
  output logic [BLK_W-1:0] startBlk,
  output logic [BLK_W-1:0] endBlk
);
  logic [SYNC_STAGES-1:0] rnbSync;
  logic rnbPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startBlk <= '0;
      endBlk <= '0;
    end else if (!strobes.freezeWindow) begin
      if (strobes.wrStart) startBlk <= wrData[BLK_W-1:0];
      if (strobes.wrEnd) endBlk <= wrData[BLK_W-1:0];
    end
  end

  assign inWindow = (cmdBlock >= startBlk) && (cmdBlock < endBlk);

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rnbSync[i] <= 1'b1;
        else if (i == 0) rnbSync[i] <= rnbIn;
        else rnbSync[i] <= rnbSync[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnbPrev <= 1'b1;
    else rnbPrev <= rnbLevel;
  end

  assign rnbLevel = rnbSync[SYNC_STAGES-1];
  assign rnbEdge = strobes.edgeFalling ? (rnbPrev & ~rnbLevel) : (~rnbPrev & rnbLevel);

  AST_WINDOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.freezeWindow |=> $stable(startBlk) && $stable(endBlk)); // R9
endmodule

// File: rtl/nbg_ctrl.sv
module nbg_ctrl
  import nbg_pkg::*;
#(
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wakeClr,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             cmdValid,
  input  logic [1:0]       cmdType,
  output logic             cmdAccept,
  output logic             cmdReject,
  input  logic             inWindow,
  input  logic             rnbLevel,
  input  logic             rnbEdge,
  input  logic [BLK_W-1:0] startBlk,
  input  logic [BLK_W-1:0] endBlk,
  output ctrlStrobe_t      strobes,
  output logic             irq
);
  logic softLock, lockTight, illEn, rnbEn, edgeFall;
  logic illFlag, rnbFlag;
  logic wrCtrl, wrStat, lockActive, isModify;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrStat = regWrEn && (regAddr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      softLock <= 1'b1;
      illEn <= 1'b0;
      rnbEn <= 1'b0;
      edgeFall <= 1'b0;
    end else if (wrCtrl) begin
      softLock <= regWdata[CTRL_SOFT];
      illEn <= regWdata[CTRL_ILL_EN];
      rnbEn <= regWdata[CTRL_RNB_EN];
      edgeFall <= regWdata[CTRL_EDGE_FALL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lockTight <= 1'b0;
    else if (wakeClr) lockTight <= 1'b0;
    else if (wrCtrl && regWdata[CTRL_TIGHT]) lockTight <= 1'b1;
  end

  assign lockActive = softLock | lockTight;
  assign isModify = (cmdType == CMD_PROG) || (cmdType == CMD_ERASE);
  assign cmdReject = cmdValid && isModify && lockActive && !inWindow;
  assign cmdAccept = cmdValid && !cmdReject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illFlag <= 1'b0;
      rnbFlag <= 1'b0;
    end else begin
      illFlag <= cmdReject | (illFlag & ~(wrStat & regWdata[STAT_ILLEGAL]));
      rnbFlag <= rnbEdge | (rnbFlag & ~(wrStat & regWdata[STAT_RNB_EV]));
    end
  end

  assign irq = (illFlag & illEn) | (rnbFlag & rnbEn);

  always_comb begin
    strobes.wrStart = regWrEn && (regAddr == ADDR_START);
    strobes.wrEnd = regWrEn && (regAddr == ADDR_END);
    strobes.freezeWindow = lockTight;
    strobes.edgeFalling = edgeFall;
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdata[CTRL_SOFT] = softLock;
        regRdata[CTRL_TIGHT] = lockTight;
        regRdata[CTRL_ILL_EN] = illEn;
        regRdata[CTRL_RNB_EN] = rnbEn;
        regRdata[CTRL_EDGE_FALL] = edgeFall;
      end
      ADDR_STAT: begin
        regRdata[STAT_RNB_EV] = rnbFlag;
        regRdata[STAT_ILLEGAL] = illFlag;
        regRdata[STAT_RNB_LVL] = rnbLevel;
      end
      ADDR_START: regRdata = REG_W'(startBlk);
      default: regRdata = REG_W'(endBlk);
    endcase
  end

  AST_NO_LOCK_NO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    !softLock && !lockTight |-> !cmdReject); // R2
  AST_READ_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && (cmdType == CMD_READ || cmdType == CMD_RSVD) |-> cmdAccept); // R5
  AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    cmdReject |=> illFlag); // R6
  AST_TIGHT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lockTight && !wakeClr |=> lockTight); // R7
  AST_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    rnbEdge |=> rnbFlag); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !illEn && !rnbEn |-> !irq); // R11
endmodule

// File: rtl/nand_block_guard.sv
module nand_block_guard
  import nbg_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wakeClr,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             cmdValid,
  input  logic [1:0]       cmdType,
  input  logic [BLK_W-1:0] cmdBlock,
  output logic             cmdAccept,
  output logic             cmdReject,
  input  logic             rnbIn,
  output logic             irq
);
  ctrlStrobe_t strobes;
  logic inWindow, rnbLevel, rnbEdge;
  logic [BLK_W-1:0] startBlk, endBlk;

  nbg_ctrl #(.BLK_W(BLK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wakeClr(wakeClr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cmdValid(cmdValid), .cmdType(cmdType), .cmdAccept(cmdAccept), .cmdReject(cmdReject),
    .inWindow(inWindow), .rnbLevel(rnbLevel), .rnbEdge(rnbEdge),
    .startBlk(startBlk), .endBlk(endBlk), .strobes(strobes), .irq(irq)
  );

  nbg_datapath #(.BLK_W(BLK_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(regWdata),
    .cmdBlock(cmdBlock), .rnbIn(rnbIn), .inWindow(inWindow),
    .rnbLevel(rnbLevel), .rnbEdge(rnbEdge), .startBlk(startBlk), .endBlk(endBlk)
  );
endmodule

// File: tb/tb_nand_block_guard.sv
`timescale 1ns/1ps
module tb_nand_block_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wakeClr = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic cmdValid = 1'b0;
  logic [1:0] cmdType = 2'd0;
  logic [15:0] cmdBlock = '0;
  logic cmdAccept, cmdReject;
  logic rnbIn = 1'b1;
  logic irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  nand_block_guard dut (
    .clk(clk), .rst_n(rst_n), .wakeClr(wakeClr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cmdValid(cmdValid), .cmdType(cmdType), .cmdBlock(cmdBlock),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .rnbIn(rnbIn), .irq(irq)
  );

  // {soft[51], start[50:35], end[34:19], type[18:17], block[16:1], expReject[0]}
  localparam int NV = 12;
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 16'd10, 16'd20, 2'd1, 16'd50, 1'b0},     // R2 lock off
    {1'b0, 16'd7, 16'd7, 2'd2, 16'd7, 1'b0},        // R2 lock off, empty window
    {1'b1, 16'd10, 16'd20, 2'd1, 16'd10, 1'b0},     // R3 first unlocked
    {1'b1, 16'd10, 16'd20, 2'd2, 16'd19, 1'b0},     // R3 last unlocked
    {1'b1, 16'd10, 16'd20, 2'd1, 16'd20, 1'b1},     // R3 end excluded
    {1'b1, 16'd10, 16'd20, 2'd2, 16'd9, 1'b1},      // R3 below start
    {1'b1, 16'd10, 16'd20, 2'd0, 16'd5, 1'b0},      // R5 read in locked
    {1'b1, 16'd10, 16'd20, 2'd3, 16'd40, 1'b0},     // R5 reserved in locked
    {1'b1, 16'd7, 16'd7, 2'd1, 16'd7, 1'b1},        // R4 equal bounds
    {1'b1, 16'd30, 16'd10, 2'd2, 16'd15, 1'b1},     // R4 inverted bounds
    {1'b1, 16'd0, 16'hFFFF, 2'd1, 16'hFFFF, 1'b1},  // R3 top block
    {1'b1, 16'd0, 16'hFFFF, 2'd2, 16'd0, 1'b0}      // R3 block zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic issue(input logic [1:0] t, input logic [15:0] b, output logic rej, output logic acc);
    @(negedge clk);
    cmdValid = 1'b1; cmdType = t; cmdBlock = b;
    #1 rej = cmdReject; acc = cmdAccept;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic rej, acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    regRead(2'd0, rd); check("R1 ctrl", rd, 16'h0001);
    regRead(2'd1, rd); check("R1 status", rd, 16'h0004);
    regRead(2'd2, rd); check("R1 start", rd, 16'h0000);
    regRead(2'd3, rd); check("R1 end", rd, 16'h0000);
    check("R1 irq", irq, 0);

    // Table walk (R2 R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      regWrite(2'd0, {15'd0, VEC[i][51]});
      regWrite(2'd2, VEC[i][50:35]);
      regWrite(2'd3, VEC[i][34:19]);
      issue(VEC[i][18:17], VEC[i][16:1], rej, acc);
      check($sformatf("R3 vec%0d reject", i), rej, VEC[i][0]);
      check($sformatf("R3 vec%0d accept", i), acc, !VEC[i][0]);
      regRead(2'd1, rd);
      check($sformatf("R6 vec%0d flag", i), rd[1], VEC[i][0]);
      regWrite(2'd1, 16'h0002);
    end

    // R6 sticky until W1C, zero write leaves it
    regWrite(2'd0, 16'h0001);
    regWrite(2'd2, 16'd10);
    regWrite(2'd3, 16'd20);
    issue(2'd1, 16'd3, rej, acc);
    repeat (5) @(negedge clk);
    regWrite(2'd1, 16'h0000);
    regRead(2'd1, rd); check("R6 flag held", rd[1], 1);
    // R11 masked, then enabled
    check("R11 irq masked", irq, 0);
    regWrite(2'd0, 16'h0005);
    #1 check("R11 irq illegal", irq, 1);
    regWrite(2'd1, 16'h0002);
    regRead(2'd1, rd); check("R6 flag cleared", rd[1], 0);
    check("R11 irq cleared", irq, 0);

    // R8 soft lock off then on
    regWrite(2'd0, 16'h0000);
    issue(2'd1, 16'd3, rej, acc); check("R8 soft cleared", acc, 1);
    regWrite(2'd0, 16'h0001);
    issue(2'd1, 16'd3, rej, acc); check("R8 soft set", rej, 1);
    regWrite(2'd1, 16'h0002);

    // R7 lock-tight sticky
    regWrite(2'd0, 16'h0002);
    regRead(2'd0, rd); check("R7 tight set", rd, 16'h0002);
    regWrite(2'd0, 16'h0000);
    regRead(2'd0, rd); check("R7 tight kept", rd, 16'h0002);
    issue(2'd2, 16'd25, rej, acc); check("R7 tight locks", rej, 1);
    regWrite(2'd1, 16'h0002);
    // R9 window frozen
    regWrite(2'd2, 16'd0);
    regWrite(2'd3, 16'd100);
    regRead(2'd2, rd); check("R9 start frozen", rd, 16'd10);
    regRead(2'd3, rd); check("R9 end frozen", rd, 16'd20);
    // R7 wake clears
    @(negedge clk); wakeClr = 1'b1;
    @(negedge clk); wakeClr = 1'b0;
    regRead(2'd0, rd); check("R7 wake clears", rd, 16'h0000);
    regWrite(2'd2, 16'd0);
    regRead(2'd2, rd); check("R9 start writable", rd, 16'd0);

    // R10 rising-edge select, enable on
    regWrite(2'd0, 16'h0008);
    @(negedge clk); rnbIn = 1'b0;
    repeat (4) @(negedge clk);
    regRead(2'd1, rd); check("R10 falling ignored", rd, 16'h0000);
    check("R11 irq quiet", irq, 0);
    @(negedge clk); rnbIn = 1'b1;
    repeat (4) @(negedge clk);
    regRead(2'd1, rd); check("R10 rising flagged", rd, 16'h0005);
    check("R11 irq rnb", irq, 1);
    regWrite(2'd1, 16'h0001);
    regRead(2'd1, rd); check("R10 w1c", rd, 16'h0004);
    // R10 falling-edge select
    regWrite(2'd0, 16'h0018);
    @(negedge clk); rnbIn = 1'b0;
    repeat (4) @(negedge clk);
    regRead(2'd1, rd); check("R10 falling flagged", rd, 16'h0001);
    regWrite(2'd1, 16'h0001);
    @(negedge clk); rnbIn = 1'b1;
    repeat (4) @(negedge clk);
    regRead(2'd1, rd); check("R10 rising ignored", rd, 16'h0004);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule